// File: doc/BRIEF.md
# CAN Status and Error Interrupt Unit

This block holds the host-visible status and error-counter view of a CAN controller. A protocol engine outside the block reports events to it as single-cycle pulses: a frame was received correctly, a frame was sent correctly, and a new last-error code is available. The engine also presents its live transmit and receive error counters. The block registers the counter values and derives three level flags from them: the warning level, the error-passive state and bus-off. It keeps sticky receive-OK and transmit-OK flags and the latest error code.

Interrupts come in two classes, each with its own enable bit. A change of the warning or bus-off flag is an error event. A receive-OK set, a transmit-OK set or an error-code update is a status-change event. Either class, when enabled, sets one pending bit, and that bit drives the interrupt line as a level. A host read of the status word clears the pending bit. Some changes never raise an interrupt: a move into or out of error-passive, and any host write to the status word.

The host reaches four word registers through a plain read/write strobe bus with combinational read data.

Top module: `can_stat_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. The registers are control (address 0), status (address 1), counters (address 2) and pending (address 3).
- R2: Status bit 6 (warning) is 1 one cycle after either counter input is at or above 96. It is 0 one cycle after both counter inputs are below 96.
- R3: Status bit 5 (error-passive) is 1 when either registered counter is at least 128. Status bit 7 (bus-off) is 1 when the registered transmit counter exceeds 255.
- R4: In the counter word, bits 7:0 hold the transmit counter saturated at 255 and bits 14:8 hold the receive counter saturated at 127. Bit 15 is 1 when the receive counter is at least 128. Bits 31:16 are 0.
- R5: When control bit 1 (error enable) is 1, a change of the warning flag or the bus-off flag sets the pending bit in the same cycle as the flag changes. When control bit 1 is 0, such a change leaves the pending bit untouched.
- R6: When control bit 0 (status enable) is 1, a receive-OK pulse, a transmit-OK pulse or an error-code update pulse sets the pending bit on the next cycle. When control bit 0 is 0, these pulses leave the pending bit untouched.
- R7: A change of the error-passive flag alone never sets the pending bit. A host write to the status word never sets it either.
- R8: A host read of address 1 clears the pending bit. If a set condition occurs in the same cycle, the pending bit stays set.
- R9: Status bit 4 (receive-OK) and bit 3 (transmit-OK) are set by their event pulses and cleared only by a host write of 0. A host write of the status word also loads bits 2:0 (error code). An event in the same cycle as such a write takes priority over the write.
- R10: Control bits 1:0 read back as written. Address 3 bit 0 shows the pending bit, and `irq_o` equals the pending bit at all times. An error-code update pulse loads `lec_i` into status bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_cnt_i | input | CNT_W | Live transmit error counter from the engine |
| rx_cnt_i | input | CNT_W | Live receive error counter from the engine |
| rx_ok_i | input | 1 | Pulse: frame received correctly |
| tx_ok_i | input | 1 | Pulse: frame transmitted correctly |
| lec_upd_i | input | 1 | Pulse: new last-error code on `lec_i` |
| lec_i | input | 3 | Last-error code value |
| bus_rd_i | input | 1 | Host read strobe |
| bus_wr_i | input | 1 | Host write strobe |
| bus_addr_i | input | 2 | Host word address |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data (combinational from address) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the clock. They also assume that the counter inputs are plain binary values, which the block registers one cycle later. Host reads and writes are never asserted together.

The stimulus drives every input on the falling edge, and it keeps read and write strobes mutually exclusive. It moves the counters in steps that cross only the thresholds each step is meant to test. Some of these steps change the error-passive flag while the warning flag holds, so that the non-interrupting path is exercised in isolation.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    localparam int LEC_W = 3;
    localparam int TXF_W = 8;
    localparam int RXF_W = 7;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_ECNT = 2'd2;
    localparam logic [1:0] ADDR_PEND = 2'd3;

    localparam int CTRL_SIE  = 0;
    localparam int CTRL_EIE  = 1;
    localparam int STAT_TXOK = 3;
    localparam int STAT_RXOK = 4;

    typedef struct packed {
        logic [LEC_W-1:0] lec;
        logic             txok;
        logic             rxok;
        logic             sie;
        logic             eie;
        logic             pend;
    } host_regs_t;

endpackage

// File: rtl/can_err_level.sv
module can_err_level
    import can_stat_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int WARN_LIM  = 96,
    parameter int PASS_LIM  = 128,
    parameter int BOFF_LIM  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    output logic             warn_o,
    output logic             epass_o,
    output logic             boff_o,
    output logic             rx_pass_o,
    output logic [TXF_W-1:0] tx_field_o,
    output logic [RXF_W-1:0] rx_field_o,
    output logic             lvl_chg_o
);

    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);
    localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIM);
    localparam logic [CNT_W-1:0] TXMAX  = CNT_W'((1 << TXF_W) - 1);
    localparam logic [CNT_W-1:0] RXMAX  = CNT_W'((1 << RXF_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic warn_nx, boff_nx;

    always_comb begin
        cnt_d    = cnt_q;
        cnt_d.tx = tx_cnt_i;
        cnt_d.rx = rx_cnt_i;
        warn_nx  = (tx_cnt_i >= WARN_V) || (rx_cnt_i >= WARN_V);
        boff_nx  = (tx_cnt_i > BOFF_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign warn_o    = (cnt_q.tx >= WARN_V) || (cnt_q.rx >= WARN_V);
    assign epass_o   = (cnt_q.tx >= PASS_V) || (cnt_q.rx >= PASS_V);
    assign boff_o    = (cnt_q.tx > BOFF_V);
    assign rx_pass_o = (cnt_q.rx >= PASS_V);
    assign lvl_chg_o = (warn_nx != warn_o) || (boff_nx != boff_o);

    generate
        if (CNT_W > TXF_W) begin : g_tx_sat
            assign tx_field_o = (cnt_q.tx > TXMAX) ? '1 : cnt_q.tx[TXF_W-1:0];
        end else begin : g_tx_ext
            assign tx_field_o = TXF_W'(cnt_q.tx);
        end
        if (CNT_W > RXF_W) begin : g_rx_sat
            assign rx_field_o = (cnt_q.rx > RXMAX) ? '1 : cnt_q.rx[RXF_W-1:0];
        end else begin : g_rx_ext
            assign rx_field_o = RXF_W'(cnt_q.rx);
        end
    endgenerate

    AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(tx_cnt_i) >= WARN_V) || ($past(rx_cnt_i) >= WARN_V))) |-> warn_o); // R2
    AST_WARN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(tx_cnt_i) < WARN_V) && ($past(rx_cnt_i) < WARN_V)) |-> !warn_o); // R2
    AST_BOFF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(tx_cnt_i) > BOFF_V)) |-> (boff_o && epass_o && (tx_field_o == '1))); // R3
    AST_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(rx_cnt_i) >= PASS_V)) |-> (rx_pass_o && (rx_field_o == '1))); // R4

endmodule

// File: rtl/can_stat_regs.sv
module can_stat_regs
    import can_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_ok_i,
    input  logic             tx_ok_i,
    input  logic             lec_upd_i,
    input  logic [LEC_W-1:0] lec_i,
    input  logic             lvl_chg_i,
    input  logic             warn_i,
    input  logic             epass_i,
    input  logic             boff_i,
    input  logic             rx_pass_i,
    input  logic [TXF_W-1:0] tx_field_i,
    input  logic [RXF_W-1:0] rx_field_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             irq_o
);

    host_regs_t r_d, r_q;
    logic stat_rd, stat_wr, ctrl_wr, any_evt, set_pend;
    logic wdata_unused;

    assign wdata_unused = ^bus_wdata_i[31:5];

    always_comb begin
        r_d      = r_q;
        stat_rd  = bus_rd_i && (bus_addr_i == ADDR_STAT);
        stat_wr  = bus_wr_i && (bus_addr_i == ADDR_STAT);
        ctrl_wr  = bus_wr_i && (bus_addr_i == ADDR_CTRL);
        any_evt  = rx_ok_i || tx_ok_i || lec_upd_i;
        set_pend = (r_q.sie && any_evt) || (r_q.eie && lvl_chg_i);

        if (ctrl_wr) begin
            r_d.sie = bus_wdata_i[CTRL_SIE];
            r_d.eie = bus_wdata_i[CTRL_EIE];
        end
        if (stat_wr) begin
            r_d.lec  = bus_wdata_i[LEC_W-1:0];
            r_d.txok = bus_wdata_i[STAT_TXOK];
            r_d.rxok = bus_wdata_i[STAT_RXOK];
        end
        if (rx_ok_i)   r_d.rxok = 1'b1;
        if (tx_ok_i)   r_d.txok = 1'b1;
        if (lec_upd_i) r_d.lec  = lec_i;

        if (stat_rd)  r_d.pend = 1'b0;
        if (set_pend) r_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr_i)
            ADDR_CTRL: bus_rdata_o = {30'd0, r_q.eie, r_q.sie};
            ADDR_STAT: bus_rdata_o = {24'd0, boff_i, warn_i, epass_i,
                                      r_q.rxok, r_q.txok, r_q.lec};
            ADDR_ECNT: bus_rdata_o = {16'd0, rx_pass_i, rx_field_i, tx_field_i};
            default:   bus_rdata_o = {31'd0, r_q.pend};
        endcase
    end

    assign irq_o = r_q.pend;

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((r_q.sie && (rx_ok_i || tx_ok_i || lec_upd_i)) || (r_q.eie && lvl_chg_i))); // R7
    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_rd && !set_pend) |-> !irq_o); // R8
    AST_RXOK_HW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rx_ok_i)) |-> r_q.rxok); // R9
    AST_RXOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_q.rxok && !(stat_wr && !bus_wdata_i[STAT_RXOK])) |-> r_q.rxok); // R9
    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_i && bus_wr_i)); // R10

endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
    import can_stat_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int BOFF_LIM = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             rx_ok_i,
    input  logic             tx_ok_i,
    input  logic             lec_upd_i,
    input  logic [2:0]       lec_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             irq_o
);

    logic             warn, epass, boff, rx_pass, lvl_chg;
    logic [TXF_W-1:0] tx_field;
    logic [RXF_W-1:0] rx_field;

    can_err_level #(
        .CNT_W    (CNT_W),
        .WARN_LIM (WARN_LIM),
        .PASS_LIM (PASS_LIM),
        .BOFF_LIM (BOFF_LIM)
    ) lvl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_cnt_i   (tx_cnt_i),
        .rx_cnt_i   (rx_cnt_i),
        .warn_o     (warn),
        .epass_o    (epass),
        .boff_o     (boff),
        .rx_pass_o  (rx_pass),
        .tx_field_o (tx_field),
        .rx_field_o (rx_field),
        .lvl_chg_o  (lvl_chg)
    );

    can_stat_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_ok_i     (rx_ok_i),
        .tx_ok_i     (tx_ok_i),
        .lec_upd_i   (lec_upd_i),
        .lec_i       (lec_i),
        .lvl_chg_i   (lvl_chg),
        .warn_i      (warn),
        .epass_i     (epass),
        .boff_i      (boff),
        .rx_pass_i   (rx_pass),
        .tx_field_i  (tx_field),
        .rx_field_i  (rx_field),
        .bus_rd_i    (bus_rd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

endmodule

// File: tb/can_stat_irq_tb.sv
module can_stat_irq_tb_top;

    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tx_cnt = '0, rx_cnt = '0;
    logic          rx_ok = 1'b0, tx_ok = 1'b0, lec_upd = 1'b0;
    logic [2:0]    lec = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    can_stat_irq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
        .rx_ok_i(rx_ok), .tx_ok_i(tx_ok), .lec_upd_i(lec_upd), .lec_i(lec),
        .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference state
    int   m_tx = 0, m_rx = 0;
    bit   m_sie = 0, m_eie = 0, m_pend = 0, m_rxok = 0, m_txok = 0;
    int   m_lec = 0;

    function automatic bit f_warn(int t, int r);
        return (t >= 96) || (r >= 96);
    endfunction
    function automatic bit f_boff(int t);
        return t > 255;
    endfunction

    function automatic logic [31:0] mread(logic [1:0] a);
        int tf, rf;
        tf = (m_tx > 255) ? 255 : m_tx;
        rf = (m_rx > 127) ? 127 : m_rx;
        case (a)
            2'd0:    return 32'(m_eie * 2 + m_sie);
            2'd1:    return 32'(f_boff(m_tx) * 128 + f_warn(m_tx, m_rx) * 64
                            + ((m_tx >= 128 || m_rx >= 128) ? 32 : 0)
                            + m_rxok * 16 + m_txok * 8 + m_lec);
            2'd2:    return 32'(((m_rx >= 128) ? 32768 : 0) + rf * 256 + tf);
            default: return 32'(m_pend);
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = 0; m_rx = 0; m_sie = 0; m_eie = 0; m_pend = 0;
            m_rxok = 0; m_txok = 0; m_lec = 0;
        end else begin
            bit chg, evt;
            chg = (f_warn(int'(tx_cnt), int'(rx_cnt)) != f_warn(m_tx, m_rx))
               || (f_boff(int'(tx_cnt)) != f_boff(m_tx));
            evt = rx_ok || tx_ok || lec_upd;
            if (rd && addr == 2'd1) m_pend = 0;
            if ((m_sie && evt) || (m_eie && chg)) m_pend = 1;
            if (wr && addr == 2'd0) begin m_sie = wdata[0]; m_eie = wdata[1]; end
            if (wr && addr == 2'd1) begin
                m_lec = int'(wdata[2:0]); m_txok = wdata[3]; m_rxok = wdata[4];
            end
            if (rx_ok)   m_rxok = 1;
            if (tx_ok)   m_txok = 1;
            if (lec_upd) m_lec = int'(lec);
            m_tx = int'(tx_cnt);
            m_rx = int'(rx_cnt);
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R10 irq level", {31'd0, irq}, {31'd0, m_pend});
            chk("R10 read data", rdata, mread(addr));
        end
    end

    task automatic step(bit r, bit w, logic [1:0] a, logic [31:0] wd,
                        bit rxo, bit txo, bit lu, logic [2:0] lv);
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = wd;
        rx_ok = rxo; tx_ok = txo; lec_upd = lu; lec = lv;
    endtask

    task automatic idle();
        step(0, 0, 2'd0, 0, 0, 0, 0, 0);
    endtask

    task automatic setcnt(int t, int r);
        @(negedge clk);
        rd = 0; wr = 0; rx_ok = 0; tx_ok = 0; lec_upd = 0;
        tx_cnt = CW'(t); rx_cnt = CW'(r);
    endtask

    task automatic rd_expect(logic [1:0] a, logic [31:0] exp, string req);
        step(1, 0, a, 0, 0, 0, 0, 0);
        #1 chk(req, rdata, exp);
    endtask

    task automatic irq_expect(bit exp, string req);
        idle();
        #1 chk(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_expect(2'd0, 32'h0, "R1 ctrl");
        rd_expect(2'd1, 32'h0, "R1 status");
        rd_expect(2'd2, 32'h0, "R1 counters");
        rd_expect(2'd3, 32'h0, "R1 pending");
        irq_expect(0, "R1 irq");
        // R10 control readback
        step(0, 1, 2'd0, 32'h3, 0, 0, 0, 0);
        rd_expect(2'd0, 32'h3, "R10 ctrl");
        // R6 receive event
        step(0, 0, 2'd0, 0, 1, 0, 0, 0);
        rd_expect(2'd3, 32'h1, "R6 rx event pending");
        rd_expect(2'd1, 32'h10, "R9 rxok set");
        irq_expect(0, "R8 read clears");
        // R6 tx + lec update, R10 lec load
        step(0, 0, 2'd0, 0, 0, 1, 1, 3'd5);
        rd_expect(2'd1, 32'h1D, "R10 lec and R6 txok");
        irq_expect(0, "R8 read clears again");
        // R7 CPU write never interrupts; R9 write clears
        step(0, 1, 2'd1, 32'h0, 0, 0, 0, 0);
        irq_expect(0, "R7 write no irq");
        rd_expect(2'd1, 32'h0, "R9 write clears flags");
        // R2/R5 warning
        setcnt(96, 0);
        irq_expect(1, "R5 warn irq");
        rd_expect(2'd1, 32'h40, "R2 warn set");
        // R7 error-passive only
        setcnt(130, 0);
        irq_expect(0, "R7 epass no irq");
        rd_expect(2'd1, 32'h60, "R3 epass");
        // R3/R4 bus-off and saturation
        setcnt(300, 200);
        irq_expect(1, "R5 boff irq");
        rd_expect(2'd2, 32'h0000FFFF, "R4 saturated fields");
        rd_expect(2'd1, 32'hE0, "R3 boff");
        setcnt(50, 100);
        irq_expect(1, "R5 boff clear irq");
        rd_expect(2'd2, 32'h00006432, "R4 fields");
        rd_expect(2'd1, 32'h40, "R2 warn from rx");
        setcnt(0, 95);
        irq_expect(1, "R5 warn clear irq");
        rd_expect(2'd1, 32'h0, "R2 warn clear");
        // enables off
        step(0, 1, 2'd0, 32'h0, 0, 0, 0, 0);
        step(0, 0, 2'd0, 0, 1, 0, 0, 0);
        irq_expect(0, "R6 disabled");
        setcnt(120, 0);
        irq_expect(0, "R5 disabled");
        // R9 event beats write
        step(0, 1, 2'd1, 32'h0, 1, 0, 0, 0);
        rd_expect(2'd1, 32'h50, "R9 hw priority");
        // R8 set beats read clear
        step(0, 1, 2'd0, 32'h1, 0, 0, 0, 0);
        step(1, 0, 2'd1, 0, 1, 0, 0, 0);
        irq_expect(1, "R8 set wins");
        rd_expect(2'd1, 32'h50, "R8 status");
        irq_expect(0, "R8 cleared");
        idle();
        idle();
        summary();
        $finish;
    end

endmodule